// File: doc/BRIEF.md
# Ethernet Receive Packet Queue

This block sits between a receive MAC byte stream and a CPU register bus. Incoming frames arrive one byte per cycle with start and end markers. Each accepted frame is written into its own fixed-size slot in a ring of slots. It is stored as a two-byte little-endian length word, the payload, the CRC-32 of the payload (least significant byte first), and zero bytes that fill out the last 32-bit word. The length word counts the payload plus the six bytes of length and CRC.

Software drains the ring through one data register. Every read returns the next four stored bytes of the oldest frame. The read that consumes the last word frees that slot and moves on to the next frame. A pending-frame count, a one-cycle receive interrupt, a drop pulse and an underflow pulse are brought out as ports. The slot count and slot size are parameters. The defaults are 31 slots of 64 bytes, which sets the largest storable payload at 58 bytes.

The bus has four word registers, selected by `busAddr`: 0 is status, 1 is receive control, 2 is data and 3 is the pending count. Reads are combinational in the cycle `busRead` is high. Side effects take place at the following clock edge.

Top module: `rx_frame_queue`

## Requirements
- R1: At most SLOTS (31) frames are pending. A frame whose start marker arrives while 31 are pending is discarded. `dropPulse` goes high for one cycle after its end byte, and the count stays at 31.
- R2: Receive control bit 0 is the enable, and it is 0 after reset. A frame whose start byte arrives while it is 0 is discarded with `dropPulse`, and the count does not change.
- R3: A stored frame of n payload bytes reads back as these bytes in order: (n+6) low byte, (n+6) high byte, the n payload bytes, 4 CRC bytes, then zero bytes up to a multiple of 4.
- R4: The CRC is reflected CRC-32 (polynomial 0xEDB88320) with all-ones start and final inversion, taken over the payload bytes only. It is stored least significant byte first.
- R5: A data read (address 2) returns 4 stored bytes with the lowest in bits 7:0 and advances by 4. The read that covers the last byte frees the slot and decrements the count. The next read starts the next frame, and slot order wraps modulo SLOTS.
- R6: A data read while the count is 0 returns 0, and `underflowPulse` is high in the next cycle.
- R7: Writing receive control with bit 4 set clears the pending count and any partly read frame. The slot read order is kept.
- R8: Storing a frame raises `rxIrq` for one cycle after the end byte and sets status bit 0. Writing status with bit 0 set clears that bit.
- R9: A frame with more than SLOT_BYTES-6 payload bytes is discarded with `dropPulse`.
- R10: The pending count reads at address 3 and on `pendingCount`. Bus writes to address 3 have no effect.
- R11: Valid bytes that do not belong to a frame (no start marker seen) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxValid | input | 1 | Receive byte valid |
| rxData | input | 8 | Receive byte |
| rxSop | input | 1 | First byte of a frame |
| rxEop | input | 1 | Last byte of a frame |
| busWrite | input | 1 | Register write strobe |
| busRead | input | 1 | Register read strobe |
| busAddr | input | 2 | Register word select |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data |
| pendingCount | output | 5 | Frames stored and not fully read |
| rxIrq | output | 1 | One-cycle pulse per stored frame |
| dropPulse | output | 1 | One-cycle pulse per discarded frame |
| underflowPulse | output | 1 | One-cycle pulse after a data read with no frame pending |

## Verification
A wrong write slot, read index or offset shows up at the very next data read as a word carrying the wrong length or payload byte. A CRC engine fault shows up on the word that holds the CRC. A count that drifts is visible at once on `pendingCount`. When a frame is dropped or committed wrongly, the drop or interrupt pulse is wrong in the cycle right after the end byte. Because of this, the bench sweeps every legal payload length, which covers every padding phase and every slot, and compares each word as it is read.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int ADDR_W = 16;

  typedef struct packed {
    logic              byteWe;
    logic [ADDR_W-1:0] byteAddr;
    logic              crcInit;
    logic              seal;
    logic [ADDR_W-1:0] baseAddr;
    logic [15:0]       frameLen;
  } dpStrobe_t;

  function automatic logic [31:0] crcStep(input logic [31:0] cIn, input logic [7:0] d);
    logic [31:0] c;
    c = cIn ^ {24'd0, d};
    for (int k = 0; k < 8; k++) begin
      c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return c;
  endfunction
endpackage

// File: rtl/rxq_datapath.sv
module rxq_datapath
  import rxq_pkg::*;
#(
  parameter int SLOTS      = 31,
  parameter int SLOT_BYTES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [7:0]        rxData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [31:0]       rdWord
);
  localparam int DEPTH = SLOTS * SLOT_BYTES;
  localparam int AW    = $clog2(DEPTH);

  logic [7:0]  mem [DEPTH];
  logic [31:0] crcReg;
  logic [31:0] crcNext;
  logic [31:0] crcOut;
  logic [1:0]  padCnt;
  logic [AW-1:0] rdA;

  assign crcNext = crcStep(stb.crcInit ? 32'hFFFF_FFFF : crcReg, rxData);
  assign crcOut  = ~crcNext;
  assign padCnt  = 2'd0 - stb.frameLen[1:0];

  always_ff @(posedge clk) begin
    if (!rstN) crcReg <= 32'hFFFF_FFFF;
    else if (stb.byteWe) crcReg <= crcNext;
  end

  always_ff @(posedge clk) begin
    if (stb.byteWe) mem[stb.byteAddr[AW-1:0]] <= rxData;
    if (stb.seal) begin
      mem[stb.baseAddr[AW-1:0]]               <= stb.frameLen[7:0];
      mem[AW'(stb.baseAddr + ADDR_W'(1))]     <= stb.frameLen[15:8];
      for (int k = 0; k < 4; k++) begin
        mem[AW'(stb.byteAddr + ADDR_W'(k + 1))] <= crcOut[8*k +: 8];
      end
      for (int k = 0; k < 3; k++) begin
        if (2'(k) < padCnt) mem[AW'(stb.byteAddr + ADDR_W'(k + 5))] <= 8'd0;
      end
    end
  end

  assign rdA    = rdAddr[AW-1:0];
  assign rdWord = {mem[rdA + AW'(3)], mem[rdA + AW'(2)], mem[rdA + AW'(1)], mem[rdA]};

  // R3
  wr_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.byteWe |-> (32'(stb.byteAddr) + 32'd4 < 32'(DEPTH)));
  // R3
  seal_with_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.seal |-> (stb.byteWe && stb.frameLen >= 16'd7));
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int SLOTS      = 31,
  parameter int SLOT_BYTES = 64,
  localparam int CW = $clog2(SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxValid,
  input  logic              rxSop,
  input  logic              rxEop,
  input  logic              busWrite,
  input  logic              busRead,
  input  logic [1:0]        busAddr,
  input  logic [31:0]       busWdata,
  input  logic [31:0]       rdWord,
  output dpStrobe_t         stb,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [31:0]       busRdata,
  output logic [CW-1:0]     pendingCount,
  output logic              rxIrq,
  output logic              dropPulse,
  output logic              underflowPulse
);
  localparam int IW = $clog2(SLOTS);
  localparam int PW = $clog2(SLOT_BYTES + 1);
  localparam logic [CW-1:0] SLOTS_C = CW'(SLOTS);
  localparam logic [PW-1:0] MAXP_C  = PW'(SLOT_BYTES - 6);

  logic [CW-1:0]     count;
  logic [IW-1:0]     rdIdx;
  logic              enable, rxFlag;
  logic              inFrame, good;
  logic [ADDR_W-1:0] wrBase;
  logic [PW-1:0]     payCnt;
  logic              rdActive;
  logic [15:0]       rdRemain;
  logic [ADDR_W-1:0] rdOfs;

  logic ctrlWr, statWr, fifoRst, startNow, inByte, curGood, fits, byteOk;
  logic frameEnd, commit, dropNow, dataRd, hasPkt, popNow, underNow;
  logic [CW:0]       slotSum, wrSlotIdx;
  logic [ADDR_W-1:0] newBase, curBase;
  logic [PW-1:0]     nNew;
  logic [15:0]       curRemain;
  logic              unusedWdata;

  assign unusedWdata = ^{busWdata[31:5], busWdata[3:1]};

  // bus decode
  assign ctrlWr  = busWrite && busAddr == 2'd1;
  assign statWr  = busWrite && busAddr == 2'd0;
  assign fifoRst = ctrlWr && busWdata[4];
  assign dataRd  = busRead && busAddr == 2'd2;

  // ingest side
  assign startNow  = rxValid && rxSop;
  assign inByte    = rxValid && (startNow || inFrame);
  assign slotSum   = (CW+1)'(rdIdx) + (CW+1)'(count);
  assign wrSlotIdx = (slotSum >= (CW+1)'(SLOTS)) ? slotSum - (CW+1)'(SLOTS) : slotSum;
  assign newBase   = ADDR_W'(wrSlotIdx) * ADDR_W'(SLOT_BYTES);
  assign curBase   = startNow ? newBase : wrBase;
  assign curGood   = startNow ? (enable && count < SLOTS_C) : good;
  assign nNew      = startNow ? PW'(1) : payCnt + PW'(1);
  assign fits      = nNew <= MAXP_C;
  assign byteOk    = inByte && curGood && fits && !fifoRst;
  assign frameEnd  = inByte && rxEop;
  assign commit    = frameEnd && byteOk;
  assign dropNow   = frameEnd && !commit;

  always_comb begin
    stb.byteWe   = byteOk;
    stb.byteAddr = curBase + ADDR_W'(nNew) + ADDR_W'(1);
    stb.crcInit  = startNow;
    stb.seal     = commit;
    stb.baseAddr = curBase;
    stb.frameLen = 16'(nNew) + 16'd6;
  end

  // drain side
  assign hasPkt    = count != '0;
  assign rdAddr    = ADDR_W'(rdIdx) * ADDR_W'(SLOT_BYTES) + (rdActive ? rdOfs : '0);
  assign curRemain = rdActive ? rdRemain : rdWord[15:0];
  assign popNow    = dataRd && hasPkt && curRemain <= 16'd4 && !fifoRst;
  assign underNow  = dataRd && !hasPkt;

  always_comb begin
    case (busAddr)
      2'd0:    busRdata = {31'd0, rxFlag};
      2'd1:    busRdata = {31'd0, enable};
      2'd2:    busRdata = hasPkt ? rdWord : 32'd0;
      default: busRdata = 32'(count);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0; rdIdx <= '0; enable <= 1'b0; rxFlag <= 1'b0;
      inFrame <= 1'b0; good <= 1'b0; wrBase <= '0; payCnt <= '0;
      rdActive <= 1'b0; rdRemain <= '0; rdOfs <= '0;
      rxIrq <= 1'b0; dropPulse <= 1'b0; underflowPulse <= 1'b0;
    end else begin
      rxIrq          <= commit;
      dropPulse      <= dropNow;
      underflowPulse <= underNow;
      if (ctrlWr) enable <= busWdata[0];
      if (commit) rxFlag <= 1'b1;
      else if (statWr && busWdata[0]) rxFlag <= 1'b0;

      if (inByte) begin
        inFrame <= !rxEop;
        good    <= byteOk;
        payCnt  <= nNew;
        wrBase  <= curBase;
      end else if (fifoRst) begin
        good <= 1'b0;
      end

      if (fifoRst) begin
        rdActive <= 1'b0;
      end else if (dataRd && hasPkt) begin
        if (popNow) begin
          rdActive <= 1'b0;
          rdIdx    <= (rdIdx == IW'(SLOTS - 1)) ? '0 : rdIdx + IW'(1);
        end else begin
          rdActive <= 1'b1;
          rdRemain <= curRemain - 16'd4;
          rdOfs    <= (rdActive ? rdOfs : '0) + ADDR_W'(4);
        end
      end

      if (fifoRst) count <= '0;
      else if (commit && !popNow) count <= count + CW'(1);
      else if (popNow && !commit) count <= count - CW'(1);
    end
  end

  assign pendingCount = count;

  // R1
  count_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= SLOTS_C);
  // R5
  pop_dec_chk: assert property (@(posedge clk) disable iff (!rstN)
    (popNow && !commit) |=> (count == $past(count) - CW'(1)));
  // R6
  under_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    underNow |-> (busRdata == 32'd0));
  // R7
  fifo_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoRst |=> (count == '0 && !rdActive));
  // R8
  irq_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq |-> rxFlag);
endmodule

// File: rtl/rx_frame_queue.sv
module rx_frame_queue
  import rxq_pkg::*;
#(
  parameter int SLOTS      = 31,
  parameter int SLOT_BYTES = 64
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         rxValid,
  input  logic [7:0]                   rxData,
  input  logic                         rxSop,
  input  logic                         rxEop,
  input  logic                         busWrite,
  input  logic                         busRead,
  input  logic [1:0]                   busAddr,
  input  logic [31:0]                  busWdata,
  output logic [31:0]                  busRdata,
  output logic [$clog2(SLOTS+1)-1:0]   pendingCount,
  output logic                         rxIrq,
  output logic                         dropPulse,
  output logic                         underflowPulse
);
  dpStrobe_t         stb;
  logic [ADDR_W-1:0] rdAddr;
  logic [31:0]       rdWord;

  rxq_ctrl #(.SLOTS(SLOTS), .SLOT_BYTES(SLOT_BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxSop(rxSop), .rxEop(rxEop),
    .busWrite(busWrite), .busRead(busRead), .busAddr(busAddr), .busWdata(busWdata),
    .rdWord(rdWord), .stb(stb), .rdAddr(rdAddr), .busRdata(busRdata),
    .pendingCount(pendingCount), .rxIrq(rxIrq), .dropPulse(dropPulse),
    .underflowPulse(underflowPulse)
  );

  rxq_datapath #(.SLOTS(SLOTS), .SLOT_BYTES(SLOT_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .rxData(rxData), .rdAddr(rdAddr), .rdWord(rdWord)
  );
endmodule

// File: tb/rx_frame_queue_tb.sv
module rx_frame_queue_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SLOTS = 31;
  localparam int SLOT_BYTES = 64;
  localparam int MAXP = SLOT_BYTES - 6;

  logic clk = 1'b0, rstN = 1'b0;
  logic rxValid = 0, rxSop = 0, rxEop = 0, busWrite = 0, busRead = 0;
  logic [7:0] rxData = 0;
  logic [1:0] busAddr = 0;
  logic [31:0] busWdata = 0, busRdata;
  logic [4:0] pendingCount;
  logic rxIrq, dropPulse, underflowPulse;
  int nChecks = 0, nFails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_frame_queue #(.SLOTS(SLOTS), .SLOT_BYTES(SLOT_BYTES)) u_dut (.*);

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] payByte(input int seed, input int i);
    return 8'(seed * 37 + i * 13 + 5);
  endfunction

  function automatic logic [31:0] crcOf(input int seed, input int n);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < n; i++) begin
      c ^= {24'd0, payByte(seed, i)};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  function automatic logic [7:0] expByte(input int seed, input int n, input int j);
    logic [15:0] len = 16'(n + 6);
    logic [31:0] crc = crcOf(seed, n);
    if (j == 0) return len[7:0];
    if (j == 1) return len[15:8];
    if (j < 2 + n) return payByte(seed, j - 2);
    if (j < n + 6) return crc[8*(j-2-n) +: 8];
    return 8'd0;
  endfunction

  task automatic sendFrame(input int seed, input int n, input bit withSop);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rxValid = 1; rxData = payByte(seed, i);
      rxSop = withSop && (i == 0); rxEop = (i == n - 1);
    end
    @(negedge clk);
    rxValid = 0; rxSop = 0; rxEop = 0;
  endtask

  task automatic busWr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrite = 1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWrite = 0;
  endtask

  task automatic busRd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    busRead = 1; busAddr = a;
    #1 d = busRdata;
    @(negedge clk);
    busRead = 0;
  endtask

  task automatic readFrame(input int seed, input int n, input string tag);
    logic [31:0] d, e;
    int words = (n + 6 + 3) / 4;
    for (int w = 0; w < words; w++) begin
      busRd(2'd2, d);
      for (int b = 0; b < 4; b++) e[8*b +: 8] = expByte(seed, n, 4*w + b);
      check(d === e, tag, d, e);
    end
  endtask

  task automatic runAll();
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // reset state (R10, R8, R2)
    check(pendingCount == 0, "R10 reset count", 32'(pendingCount), 0);
    check(rxIrq == 0, "R8 reset irq", 32'(rxIrq), 0);
    busRd(2'd1, d); check(d == 0, "R2 reset enable", d, 0);
    busRd(2'd0, d); check(d == 0, "R8 reset status", d, 0);

    // R2: disabled queue discards
    sendFrame(1, 5, 1);
    check(dropPulse == 1, "R2 drop when disabled", 32'(dropPulse), 1);
    check(pendingCount == 0, "R2 count unchanged", 32'(pendingCount), 0);
    busWr(2'd1, 32'h1);

    // R11: bytes without a start marker
    sendFrame(2, 4, 0);
    check(pendingCount == 0, "R11 stray bytes", 32'(pendingCount), 0);
    check(dropPulse == 0, "R11 no drop", 32'(dropPulse), 0);

    // R3 R4 R5 sweep of every legal length; 58 frames wrap the slot ring
    for (int n = 1; n <= MAXP; n++) begin
      sendFrame(n + 10, n, 1);
      check(rxIrq == 1, "R8 irq pulse", 32'(rxIrq), 1);
      check(pendingCount == 1, "R5 count after store", 32'(pendingCount), 1);
      readFrame(n + 10, n, "R3/R4 frame words");
      check(pendingCount == 0, "R5 slot freed", 32'(pendingCount), 0);
    end

    // R8 status clear; R10 count register read-only
    busRd(2'd0, d); check(d == 1, "R8 status set", d, 1);
    busWr(2'd0, 32'h1);
    busRd(2'd0, d); check(d == 0, "R8 status cleared", d, 0);
    sendFrame(3, 9, 1);
    busWr(2'd3, 32'h0);
    busRd(2'd3, d); check(d == 1, "R10 write ignored", d, 1);
    readFrame(3, 9, "R10 frame intact");

    // R9: too long
    sendFrame(4, MAXP + 1, 1);
    check(dropPulse == 1, "R9 drop long", 32'(dropPulse), 1);
    check(pendingCount == 0, "R9 count", 32'(pendingCount), 0);

    // R1: fill ring, overflow, drain in order
    for (int k = 0; k < SLOTS; k++) sendFrame(100 + k, 1 + (k * 7) % MAXP, 1);
    check(pendingCount == 31, "R1 full", 32'(pendingCount), 31);
    sendFrame(99, 6, 1);
    check(dropPulse == 1, "R1 drop when full", 32'(dropPulse), 1);
    check(pendingCount == 31, "R1 count held", 32'(pendingCount), 31);
    for (int k = 0; k < SLOTS; k++) readFrame(100 + k, 1 + (k * 7) % MAXP, "R1/R5 drain order");
    check(pendingCount == 0, "R1 drained", 32'(pendingCount), 0);

    // R6 underflow
    busRd(2'd2, d);
    check(d == 0, "R6 underflow data", d, 0);
    check(underflowPulse == 1, "R6 underflow pulse", 32'(underflowPulse), 1);

    // R7 FIFO reset with a partly read frame
    sendFrame(5, 10, 1);
    sendFrame(6, 20, 1);
    busRd(2'd2, d);
    busWr(2'd1, 32'h11);
    check(pendingCount == 0, "R7 count cleared", 32'(pendingCount), 0);
    sendFrame(7, 13, 1);
    readFrame(7, 13, "R7 fresh frame after reset");
    check(pendingCount == 0, "R7 final count", 32'(pendingCount), 0);
  endtask

  initial begin
    fork
      runAll();
      begin
        repeat (150000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule